// File: doc/BRIEF.md
# Tone-or-Echo DAC Sample Source

This block supplies the 16-bit word that a codec DAC receives once per serial frame. Every time a sample arrives from the codec ADC (a one-cycle strobe with its data word), the block answers with exactly one outgoing sample on the following clock. Bit 0 of a received word is a control-request flag, not audio. The block clears it on every word it takes in, and it never sets it on a word it sends out.

Two sources are available. In echo mode the received word goes straight back with bit 0 cleared. This is a digital loop through which any filtering stage could later be inserted. In tone mode the block walks a cyclic 3-bit index around an 8-point sine table whose peak sits 3 dB below full scale, and sends the entry it lands on. The index moves by a programmable stride on every received sample and wraps modulo 8. A stride of 1 at an 8 kHz frame rate gives a 1 kHz tone. The stride is taken from an input only when the mode select changes, so that input can move freely while a tone is running.

Top module: `tone_echo_source`

## Requirements
- R1: `txValid` is high on the clock cycle directly after each cycle in which `rxValid` is high, and low after every cycle in which `rxValid` is low; there is exactly one output sample per received sample.
- R2: Bit 0 of `txData` is 0 whenever `txValid` is high, in both modes.
- R3: When `toneMode` is 0 during a strobe, `txData` on the next cycle equals the received `rxData` with bit 0 forced to 0 and bits 15..1 unchanged.
- R4: The tone table, indexed 0 to 7, holds the two's-complement values 0, 16384, 23170, 16384, 0, -16384, -23170, -16384.
- R5: When `toneMode` is 1 during a strobe, the index becomes (index + stride) mod 8 and `txData` on the next cycle is the table entry at the new index.
- R6: After reset the index is 0, the stride is 1, the remembered mode is echo (0), and `txValid` and `txData` are 0. The first tone strobe after reset, without a mode change having loaded a new stride, yields 16384.
- R7: The stride is loaded from `stepIn` only on a clock edge where `toneMode` differs from its value at the previous edge. A strobe on that same edge already uses the newly loaded stride. On all other edges `stepIn` has no effect.
- R8: Strobes in echo mode do not move the index, so tone output resumes from where it stopped.
- R9: `txData` holds its value on every cycle that follows a cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | One-cycle strobe: a received ADC sample is present |
| rxData | input | 16 | Received ADC sample word; bit 0 is a control-request flag |
| toneMode | input | 1 | 1 = sine table source, 0 = echo of received sample |
| stepIn | input | 3 | Table stride, captured when `toneMode` changes |
| txValid | output | 1 | One-cycle strobe: outgoing DAC sample is ready |
| txData | output | 16 | Outgoing DAC sample, bit 0 always 0 |

## Verification
Two functions can fall on the same edge: loading a new stride on a mode toggle, and the tone index advancing on a receive strobe. The bench provokes the overlap by raising `toneMode` together with `rxValid` for every stride from 0 to 7, after first parking a different stride in `stepIn`. It judges the result against its own model, which requires the very first tone sample after the toggle to already be the entry at (old index + new stride) mod 8. It then follows the tone for 17 further strobes while it wiggles `stepIn`, to confirm that the captured stride stays fixed until the next toggle.

// File: rtl/tes_pkg.sv
package tes_pkg;

  // Strobes passed from the control block to the datapath each cycle.
  typedef struct packed {
    logic sample;    // a received word is consumed this cycle
    logic tone;      // the outgoing word comes from the sine table
    logic advance;   // the table index moves this cycle
    logic loadStep;  // the mode select toggled: capture a new stride
  } ctrlStb_t;

  localparam int unsigned TONE_POINTS = 8;

  // Table entries at -3 dB re full scale; every entry is even.
  function automatic logic signed [15:0] toneEntry(input logic [2:0] k);
    logic signed [15:0] v;
    case (k)
      3'd0:    v = 16'sd0;
      3'd1:    v = 16'sd16384;
      3'd2:    v = 16'sd23170;
      3'd3:    v = 16'sd16384;
      3'd4:    v = 16'sd0;
      3'd5:    v = -16'sd16384;
      3'd6:    v = -16'sd23170;
      default: v = -16'sd16384;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/tes_control.sv
module tes_control
  import tes_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     rxValid,
  input  logic     toneMode,
  output ctrlStb_t stb,
  output logic     txValid
);

  logic modePrev;
  logic txValidQ;

  always_comb begin
    stb.sample   = rxValid;
    stb.tone     = toneMode;
    stb.advance  = rxValid & toneMode;
    stb.loadStep = toneMode ^ modePrev;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modePrev <= 1'b0;
      txValidQ <= 1'b0;
    end else begin
      modePrev <= toneMode;
      txValidQ <= rxValid;
    end
  end

  assign txValid = txValidQ;

  AST_NO_ADVANCE_IN_ECHO: assert property (@(posedge clk) disable iff (!rstN)
    !toneMode |-> !stb.advance);  // R8

endmodule

// File: rtl/tes_datapath.sv
module tes_datapath
  import tes_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned STEP_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [DATA_W-1:0] rxData,
  input  logic [STEP_W-1:0] stepIn,
  output logic [DATA_W-1:0] txData
);

  localparam int unsigned IDX_W = $clog2(TONE_POINTS);
  localparam int unsigned SUM_W = IDX_W + 1;

  logic [STEP_W-1:0] stepQ;
  logic [STEP_W-1:0] stepEff;
  logic [IDX_W-1:0]  idxQ;
  logic [IDX_W-1:0]  idxNext;
  logic [SUM_W-1:0]  idxSum;
  logic [DATA_W-1:0] rxMasked;
  logic [DATA_W-1:0] toneWord;
  logic [DATA_W-1:0] outNext;
  logic [DATA_W-1:0] txQ;

  // Stride used this cycle: a toggle edge already applies the new one.
  assign stepEff = stb.loadStep ? stepIn : stepQ;

  always_comb begin
    idxSum = SUM_W'(idxQ) + SUM_W'(stepEff);
    if (idxSum >= SUM_W'(TONE_POINTS))
      idxSum = idxSum - SUM_W'(TONE_POINTS);
    idxNext = idxSum[IDX_W-1:0];
  end

  // The request flag in bit 0 is dropped on the way in and on the way out.
  assign rxMasked = {rxData[DATA_W-1:1], 1'b0};
  assign toneWord = {DATA_W'(toneEntry(idxNext)) >> 1, 1'b0} [DATA_W-1:0];
  assign outNext  = stb.tone ? toneWord : rxMasked;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepQ <= STEP_W'(1);
      idxQ  <= '0;
      txQ   <= '0;
    end else begin
      if (stb.loadStep) stepQ <= stepIn;
      if (stb.advance)  idxQ  <= idxNext;
      if (stb.sample)   txQ   <= outNext;
    end
  end

  assign txData = txQ;

  AST_STEP_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadStep |=> $stable(stepQ));  // R7
  AST_IDX_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !stb.advance |=> $stable(idxQ));  // R8
  AST_IDX_MOVES_BY_STRIDE: assert property (@(posedge clk) disable iff (!rstN)
    stb.advance |=> (idxQ == IDX_W'($past(idxQ) + $past(stepEff))));  // R5

endmodule

// File: rtl/tone_echo_source.sv
module tone_echo_source
  import tes_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned STEP_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic              toneMode,
  input  logic [STEP_W-1:0] stepIn,
  output logic              txValid,
  output logic [DATA_W-1:0] txData
);

  ctrlStb_t stb;

  tes_control i_control (
    .clk      (clk),
    .rstN     (rstN),
    .rxValid  (rxValid),
    .toneMode (toneMode),
    .stb      (stb),
    .txValid  (txValid)
  );

  tes_datapath #(.DATA_W(DATA_W), .STEP_W(STEP_W)) i_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .rxData (rxData),
    .stepIn (stepIn),
    .txData (txData)
  );

  AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> txValid);  // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> !txValid);  // R1
  AST_LSB_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (txData[0] == 1'b0));  // R2
  AST_ECHO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !toneMode) |=> (txData[DATA_W-1:1] == $past(rxData[DATA_W-1:1])));  // R3
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> $stable(txData));  // R9

endmodule

// File: tb/test_tone_echo_source.sv
module test_tone_echo_source;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 1'b0;
  logic [15:0] rxData = '0;
  logic        toneMode = 1'b0;
  logic [2:0]  stepIn = '0;
  logic        txValid;
  logic [15:0] txData;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model
  int  mIdx = 0;
  int  mStep = 1;
  bit  mPrev = 0;
  logic [15:0] mData = '0;
  logic [15:0] tab [8];

  always #4 clk = ~clk;

  tone_echo_source i_tone_echo_source (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .toneMode(toneMode), .stepIn(stepIn), .txValid(txValid), .txData(txData)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one cycle at a negedge, update the model at the edge, check after it.
  task automatic cycle(input bit rv, input logic [15:0] d, input bit tm, input logic [2:0] st,
                       input string req);
    bit toggled;
    int eff;
    rxValid = rv; rxData = d; toneMode = tm; stepIn = st;
    @(posedge clk);
    toggled = (tm != mPrev);
    eff = toggled ? int'(st) : mStep;
    if (rv) begin
      if (tm) begin
        mIdx = (mIdx + eff) % 8;
        mData = tab[mIdx];
      end else mData = {d[15:1], 1'b0};
    end
    if (toggled) mStep = eff;
    mPrev = tm;
    @(negedge clk);
    check({req, " R1 valid"}, {15'd0, txValid}, {15'd0, rv});
    check(req, txData, mData);
    if (rv) check("R2 lsb", {15'd0, txData[0]}, 16'd0);
  endtask

  initial begin
    for (int k = 0; k < 8; k++) begin
      real v;
      v = (32768.0 / $sqrt(2.0)) * $sin(3.14159265358979 * k / 4.0);
      tab[k] = 16'($rtoi(v >= 0.0 ? v + 0.5 : v - 0.5));
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R6: reset state
    check("R6 reset valid", {15'd0, txValid}, 16'd0);
    check("R6 reset data", txData, 16'd0);
    // R4 / R6: tone with no toggle-loaded stride is impossible; toggle with stride 1
    cycle(1, 16'h0000, 1, 3'd1, "R6 first tone");
    check("R4 entry1", txData, 16'd16384);
    for (int n = 0; n < 7; n++) cycle(1, 16'hFFFF, 1, 3'd5, "R4 table walk");
    check("R5 wrap to 0", txData, 16'd0);
    // R3: echo sweep incl. LSB set patterns
    cycle(0, 16'h1234, 0, 3'd0, "R9 hold");
    for (int p = 0; p < 64; p++)
      cycle(1, 16'((p * 16'h0407) ^ (p << 9) | (p & 1)), 0, 3'(p), "R3 echo");
    cycle(1, 16'hFFFF, 0, 3'd7, "R3 all ones");
    cycle(1, 16'h8001, 0, 3'd7, "R3 min");
    // R7/R5: toggle coinciding with strobe for every stride
    for (int s = 0; s < 8; s++) begin
      cycle(1, 16'h0001, 0, 3'(s + 3), "R8 echo no advance");
      cycle(1, 16'h0000, 1, 3'(s), "R7 toggle with strobe");
      for (int n = 0; n < 17; n++) begin
        cycle(1, 16'h0000, 1, 3'(n), "R5 stride walk R7 ignored");
        if (n % 5 == 0) cycle(0, 16'hABCD, 1, 3'(n + 1), "R9 hold tone");
      end
    end
    // R7: toggle without strobe, then strobes
    cycle(0, 16'h0, 0, 3'd2, "R9 toggle no strobe");
    cycle(0, 16'h0, 1, 3'd3, "R7 load no strobe");
    for (int n = 0; n < 9; n++) cycle(1, 16'h0, 1, 3'd6, "R5 stride 3");
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule